// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit tri-state buses, called A and B, and keeps one storage register for each transfer direction. The A-to-B register takes in the A bus on the rising edge of its own clock. The B-to-A register takes in the B bus on the rising edge of a separate clock. Capture is never gated by the output controls, so the block can log traffic while it is isolated.

An active-low output enable and a direction input decide which bus the block drives, if it drives either one. For each direction, a select input decides whether the driven bus carries the live value of the opposite bus or the value held in that direction's register. Every bit channel is identical and passes data without inversion. The block reads a bus from the resolved pin value. So a register clocked from a bus that the block is driving captures the block's own output.

Top module: `bxr_transceiver`

## Requirements
- R1: On a rising edge of `clk_ab` with `rst_n` high, the A-to-B register loads the value present on `bus_a`.
- R2: On a rising edge of `clk_ba` with `rst_n` high, the B-to-A register loads the value present on `bus_b`.
- R3: Register capture takes place for every setting of `oe_n`, `dir`, `sel_ab` and `sel_ba`.
- R4: While `oe_n` is 1, the block drives neither `bus_a` nor `bus_b`; both pins read high-impedance unless driven from outside.
- R5: While `oe_n` is 0 and `dir` is 0, the block drives `bus_a`: with the live `bus_b` value when `sel_ba` is 0, and with the B-to-A register when `sel_ba` is 1.
- R6: While `oe_n` is 0 and `dir` is 1, the block drives `bus_b`: with the live `bus_a` value when `sel_ab` is 0, and with the A-to-B register when `sel_ab` is 1.
- R7: The block never drives both buses at once; the bus it does not drive is left high-impedance.
- R8: A register clocked from the bus the block is driving loads the value the block itself puts on that bus.
- R9: A rising edge of either capture clock while `rst_n` is 0 clears that clock's register to 8'h00.
- R10: Each of the 8 bit channels carries its bit unchanged, in its own bit position, with no inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock for the A-to-B register (rising edge) |
| clk_ba | input | 1 | Capture clock for the B-to-A register (rising edge) |
| rst_n | input | 1 | Active-low reset, sampled on each capture clock |
| oe_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir | input | 1 | 0 drives bus A, 1 drives bus B |
| sel_ab | input | 1 | B-side source: 0 live A, 1 stored A-to-B register |
| sel_ba | input | 1 | A-side source: 0 live B, 1 stored B-to-A register |
| bus_a | inout | 8 | Bus A data pins |
| bus_b | inout | 8 | Bus B data pins |

## Verification
The live path is tried with all-zero, all-one, alternating and single-bit patterns in both directions. These patterns show up a stuck, inverted or swapped channel. The stored path is checked while the live bus holds a different value from the register, so a wrong select setting is visible at once. Captures are taken both in isolation and with the outputs enabled, which separates capture that is always on from capture gated by the output enables. A capture from the bus the block is driving, read back later through the other direction, shows that the register samples the resolved pin and that only one bus is driven.

// File: rtl/bxr_pkg.sv
// Shared definitions for the registered bus transceiver.
// Assumes: one output mode is active at a time, derived from oe_n and dir.
package bxr_pkg;
    localparam int unsigned BXR_WIDTH = 8;

    typedef enum logic [1:0] {
        MODE_ISOLATE = 2'b00,
        MODE_DRIVE_A = 2'b01,
        MODE_DRIVE_B = 2'b10
    } bxr_mode_e;
endpackage

// File: rtl/bxr_capture_reg.sv
// Storage register for one transfer direction.
// Loads d on every rising clk edge and clears on an edge while rst_n is low.
// Assumes: the caller feeds the resolved bus value, and no enable gates capture.
module bxr_capture_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Capture the bus value, or clear it during a synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/bxr_path_sel.sv
// Per-bit source selector for one direction: live opposite bus or stored value.
// Assumes: the bit channels are identical and none of them inverts data.
module bxr_path_sel #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             use_stored,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] y
);
    for (genvar ch = 0; ch < WIDTH; ch++) begin : g_chan
        // Pick the source for this bit channel.
        always_comb begin
            y[ch] = use_stored ? stored[ch] : live[ch];
        end
    end
endmodule

// File: rtl/bxr_drive_ctrl.sv
// Decodes the output enable and direction into a mode and per-bus drive enables.
// Assumes: isolation takes priority over direction, and at most one bus is enabled.
module bxr_drive_ctrl
    import bxr_pkg::*;
(
    input  logic      oe_n,
    input  logic      dir,
    output bxr_mode_e mode,
    output logic      drive_a,
    output logic      drive_b
);
    // Pick the output mode from the controls.
    always_comb begin
        if (oe_n)     mode = MODE_ISOLATE;
        else if (dir) mode = MODE_DRIVE_B;
        else          mode = MODE_DRIVE_A;
    end

    // Turn the mode into bus enables.
    always_comb begin
        drive_a = (mode == MODE_DRIVE_A);
        drive_b = (mode == MODE_DRIVE_B);
    end
endmodule

// File: rtl/bxr_transceiver.sv
// Top level: 8-bit two-way transceiver with a storage register per direction.
// Registers sample the resolved bus pins. Tri-state drivers sit only here.
// Assumes: the outside world does not drive the bus this block is driving.
module bxr_transceiver
    import bxr_pkg::*;
#(
    parameter int unsigned WIDTH = BXR_WIDTH
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst_n,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    inout  wire  [WIDTH-1:0] bus_a,
    inout  wire  [WIDTH-1:0] bus_b
);
    logic [WIDTH-1:0] reg_ab;
    logic [WIDTH-1:0] reg_ba;
    logic [WIDTH-1:0] out_a;
    logic [WIDTH-1:0] out_b;
    logic             drive_a;
    logic             drive_b;
    bxr_mode_e        mode;

    bxr_capture_reg #(.WIDTH(WIDTH)) u_reg_ab (
        .clk(clk_ab), .rst_n(rst_n), .d(bus_a), .q(reg_ab)
    );

    bxr_capture_reg #(.WIDTH(WIDTH)) u_reg_ba (
        .clk(clk_ba), .rst_n(rst_n), .d(bus_b), .q(reg_ba)
    );

    bxr_path_sel #(.WIDTH(WIDTH)) u_sel_to_b (
        .use_stored(sel_ab), .live(bus_a), .stored(reg_ab), .y(out_b)
    );

    bxr_path_sel #(.WIDTH(WIDTH)) u_sel_to_a (
        .use_stored(sel_ba), .live(bus_b), .stored(reg_ba), .y(out_a)
    );

    bxr_drive_ctrl u_ctrl (
        .oe_n(oe_n), .dir(dir), .mode(mode),
        .drive_a(drive_a), .drive_b(drive_b)
    );

    // Tri-state pin drivers, enabled only in their own mode.
    assign bus_a = (drive_a && mode == MODE_DRIVE_A) ? out_a : {WIDTH{1'bz}};
    assign bus_b = (drive_b && mode == MODE_DRIVE_B) ? out_b : {WIDTH{1'bz}};
endmodule

// File: rtl/bxr_transceiver_chk.sv
// Checker for bxr_transceiver: relates controls, bus pins and registers.
// Assumes: it is sampled on the capture clocks; bound to every instance below.
module bxr_transceiver_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk_ab,
    input logic             clk_ba,
    input logic             rst_n,
    input logic             oe_n,
    input logic             dir,
    input logic             sel_ab,
    input logic             sel_ba,
    input logic [WIDTH-1:0] bus_a,
    input logic [WIDTH-1:0] bus_b,
    input logic [WIDTH-1:0] reg_ab,
    input logic [WIDTH-1:0] reg_ba,
    input logic             drive_a,
    input logic             drive_b
);
    // R1
    ab_capture_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
        rst_n |=> reg_ab == $past(bus_a));

    // R2
    ba_capture_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
        rst_n |=> reg_ba == $past(bus_b));

    // R4
    isolate_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
        oe_n |-> (!drive_a && !drive_b));

    // R7
    single_bus_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
        $countones({drive_a, drive_b}) <= 1);

    // R6
    stored_to_b_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (!oe_n && dir && sel_ab) |-> bus_b == reg_ab);

    // R5
    stored_to_a_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (!oe_n && !dir && sel_ba) |-> bus_a == reg_ba);
endmodule

bind bxr_transceiver bxr_transceiver_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .bus_a(bus_a), .bus_b(bus_b),
    .reg_ab(reg_ab), .reg_ba(reg_ba), .drive_a(drive_a), .drive_b(drive_b)
);

// File: tb/bxr_transceiver_tb_top.sv
// Directed bench for bxr_transceiver: one task per scenario, each checking itself.
module bxr_transceiver_tb_top;
    logic       clk = 1'b0;
    logic       clk_ab = 1'b0;
    logic       clk_ba = 1'b0;
    logic       rst_n = 1'b0;
    logic       oe_n = 1'b1;
    logic       dir = 1'b0;
    logic       sel_ab = 1'b0;
    logic       sel_ba = 1'b0;
    logic [7:0] a_drv = 8'h00;
    logic [7:0] b_drv = 8'h00;
    logic       a_en = 1'b0;
    logic       b_en = 1'b0;
    wire  [7:0] bus_a;
    wire  [7:0] bus_b;
    int         n_chk = 0;
    int         n_bad = 0;

    assign bus_a = a_en ? a_drv : 8'bz;
    assign bus_b = b_en ? b_drv : 8'bz;

    always #2.5 clk = ~clk;

    bxr_transceiver dut_i (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n),
        .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .bus_a(bus_a), .bus_b(bus_b)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_ab();
        @(negedge clk); clk_ab = 1'b1;
        @(negedge clk); clk_ab = 1'b0;
    endtask

    task automatic pulse_ba();
        @(negedge clk); clk_ba = 1'b1;
        @(negedge clk); clk_ba = 1'b0;
    endtask

    // R9: reset clears both registers
    task automatic t_reset();
        rst_n = 1'b0; oe_n = 1'b1;
        a_en = 1'b1; a_drv = 8'hFF; b_en = 1'b1; b_drv = 8'hFF;
        pulse_ab(); pulse_ba();
        rst_n = 1'b1;
        a_drv = 8'h11; b_en = 1'b0; oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
        settle();
        check("R9 reg_ab cleared", bus_b, 8'h00);
        b_en = 1'b1; b_drv = 8'h22; a_en = 1'b0; dir = 1'b0; sel_ba = 1'b1;
        settle();
        check("R9 reg_ba cleared", bus_a, 8'h00);
    endtask

    // R4, R1, R2, R3: isolation, with capture still working
    task automatic t_isolation();
        oe_n = 1'b1; a_en = 1'b0; b_en = 1'b0;
        settle();
        check("R4 bus_a undriven", bus_a, 8'bz);
        check("R4 bus_b undriven", bus_b, 8'bz);
        a_en = 1'b1; a_drv = 8'h5A; pulse_ab(); a_en = 1'b0;
        b_en = 1'b1; b_drv = 8'hC3; pulse_ba(); b_en = 1'b0;
        settle();
        check("R4 bus_a undriven after capture", bus_a, 8'bz);
        a_en = 1'b1; a_drv = 8'h00; oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
        settle();
        check("R1 R3 isolated capture A", bus_b, 8'h5A);
        a_en = 1'b0; b_en = 1'b1; b_drv = 8'h00; dir = 1'b0; sel_ba = 1'b1;
        settle();
        check("R2 R3 isolated capture B", bus_a, 8'hC3);
    endtask

    // R6, R10, R7: drive B from the live A bus and from the stored register
    task automatic t_drive_b();
        logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h01, 8'h80};
        b_en = 1'b0; a_en = 1'b1; oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0;
        for (int i = 0; i < 5; i++) begin
            a_drv = pats[i];
            settle();
            check("R6 R10 live A to B", bus_b, pats[i]);
            check("R7 bus_a not fought", bus_a, pats[i]);
        end
        sel_ab = 1'b1;
        settle();
        check("R6 stored A to B", bus_b, 8'h5A);
        a_en = 1'b0;
        settle();
        check("R7 bus_a released", bus_a, 8'bz);
    endtask

    // R5, R10, R7: drive A from the live B bus and from the stored register
    task automatic t_drive_a();
        logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'h5A, 8'h02, 8'h40};
        a_en = 1'b0; b_en = 1'b1; oe_n = 1'b0; dir = 1'b0; sel_ba = 1'b0;
        for (int i = 0; i < 5; i++) begin
            b_drv = pats[i];
            settle();
            check("R5 R10 live B to A", bus_a, pats[i]);
        end
        sel_ba = 1'b1; b_drv = 8'h0F;
        settle();
        check("R5 stored B to A", bus_a, 8'hC3);
        b_en = 1'b0;
        settle();
        check("R7 bus_b released", bus_b, 8'bz);
    endtask

    // R3: capture with outputs enabled
    task automatic t_capture_enabled();
        b_en = 1'b0; a_en = 1'b1; a_drv = 8'h3C; oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
        pulse_ab();
        settle();
        check("R3 capture while enabled", bus_b, 8'h3C);
    endtask

    // R8: register clocked from the bus the block drives takes its own output
    task automatic t_own_capture();
        b_en = 1'b0; a_en = 1'b1; a_drv = 8'h77; oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0;
        settle();
        pulse_ba();
        a_en = 1'b0; dir = 1'b0; sel_ba = 1'b1; b_en = 1'b1; b_drv = 8'h00;
        settle();
        check("R8 own output captured", bus_a, 8'h77);
    endtask

    initial begin
        t_reset();
        t_isolation();
        t_drive_b();
        t_drive_a();
        t_capture_enabled();
        t_own_capture();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule